// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the column address for each beat of a synchronous DRAM burst. A request carries a starting column, a burst length of 2, 4 or 8 beats, and an ordering choice. The ordering is either a wrap-around count or a bitwise-XOR walk. Both orders stay inside the aligned block of columns that holds the starting column. Only the low column bits covered by the burst length move from beat to beat. Every column bit above them keeps the value it had in the starting column.

A controller pulses the start strobe together with the request. The block then presents one column per clock, with a valid flag and a flag that marks the final beat. It takes no new request until the current burst has ended, so the start strobe has no effect while a burst is running.

Top module: `bcol_gen`

## Requirements
- R1: `len_i` selects the burst length: code 0 gives 2 beats, code 1 gives 4 beats, code 2 gives 8 beats, and code 3 also gives 8 beats. `beat_vld_o` stays high for exactly that many consecutive cycles.
- R2: A start strobe sampled while the block is idle is accepted. In the next cycle `beat_vld_o` is high and `col_o` equals `col_i` as it was sampled with the strobe.
- R3: With `ilv_i` = 0 (sequential order), the field of length N (bits [0], [1:0] or [2:0]) on beat k equals (start field + k) mod N.
- R4: With `ilv_i` = 1 (interleave order), the field on beat k equals the start field XOR k.
- R5: Every column bit above the moving field holds the value from the starting column for the whole burst. This includes the bits of [2:0] that lie outside a 2-beat or 4-beat field.
- R6: `last_o` is high on the final beat of each burst and low on every other cycle.
- R7: A start strobe that arrives while a burst is running is ignored. This holds on the final beat as well. The burst keeps its addresses, and `beat_vld_o` is low in the cycle after the final beat.
- R8: While `rst` is high, and in the cycle that follows it, `beat_vld_o` and `last_o` are low and `col_o` is zero. `col_o` is also zero whenever no beat is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts a burst when the block is idle |
| col_i | input | COL_W | Starting column address |
| len_i | input | 2 | Burst length code (0:2, 1:4, 2:8, 3:8) |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleave |
| beat_vld_o | output | 1 | A beat is being presented |
| col_o | output | COL_W | Column address of the current beat |
| last_o | output | 1 | Final beat of the burst |

## Verification
A short table of hand-worked bursts is run first. These are a start of 5 at length 8 in both orders, a start of 1 at lengths 4 and 2, a start of 7 at length 4 with high upper bits, and length code 3. They separate a wrap-around count from an XOR walk, and at length 2 they show that the two orders agree. A sweep then runs every starting value of the low three bits, at every length and in both orders. The upper bits change from burst to burst, which shows whether bits outside the field leak into the sequence. Directed tests hold the start strobe high through a whole burst with a different column, check the idle cycle after the final beat, and check the outputs during and just after reset.

// File: rtl/bcol_pkg.sv
package bcol_pkg;

    localparam int LOW_W = 3;

    typedef enum logic [1:0] {
        LEN_2  = 2'd0,
        LEN_4  = 2'd1,
        LEN_8  = 2'd2,
        LEN_8B = 2'd3
    } len_code_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

    typedef struct packed {
        logic [LOW_W-1:0] seed;
        logic [LOW_W-1:0] span;
        order_e           order;
    } low_req_t;

    function automatic logic [LOW_W-1:0] span_of(len_code_e code);
        logic [LOW_W-1:0] m;
        case (code)
            LEN_2:   m = 3'b001;
            LEN_4:   m = 3'b011;
            default: m = 3'b111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bcol_capture.sv
module bcol_capture
    import bcol_pkg::*;
#(
    parameter int COL_W = 10,
    localparam int HI_W = COL_W - LOW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [COL_W-1:0] col,
    input  logic [1:0]       len,
    input  logic             ilv,
    output logic [HI_W-1:0]  hi_q,
    output low_req_t         req_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            req_q <= '{seed: '0, span: 3'b001, order: ORD_SEQ};
        end else if (load) begin
            hi_q        <= col[COL_W-1:LOW_W];
            req_q.seed  <= col[LOW_W-1:0];
            req_q.span  <= span_of(len_code_e'(len));
            req_q.order <= order_e'(ilv);
        end
    end

endmodule

// File: rtl/bcol_beat_cnt.sv
module bcol_beat_cnt
    import bcol_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LOW_W-1:0] span,
    output logic             busy,
    output logic [LOW_W-1:0] beat,
    output logic             final_beat
);

    assign final_beat = busy && (beat == span);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            beat <= '0;
        end else if (load) begin
            busy <= 1'b1;
            beat <= '0;
        end else if (busy) begin
            if (final_beat) begin
                busy <= 1'b0;
                beat <= '0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcol_order.sv
module bcol_order
    import bcol_pkg::*;
(
    input  low_req_t         req,
    input  logic [LOW_W-1:0] beat,
    output logic [LOW_W-1:0] low
);

    logic [LOW_W-1:0] sum;

    assign sum = req.seed + beat;

    for (genvar b = 0; b < LOW_W; b++) begin : g_bit
        always_comb begin
            if (!req.span[b])
                low[b] = req.seed[b];
            else if (req.order == ORD_XOR)
                low[b] = req.seed[b] ^ beat[b];
            else
                low[b] = sum[b];
        end
    end

endmodule

// File: rtl/bcol_gen.sv
module bcol_gen
    import bcol_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [1:0]       len_i,
    input  logic             ilv_i,
    output logic             beat_vld_o,
    output logic [COL_W-1:0] col_o,
    output logic             last_o
);

    localparam int HI_W = COL_W - LOW_W;

    logic             busy;
    logic             load;
    logic [LOW_W-1:0] beat;
    logic [LOW_W-1:0] low;
    logic [HI_W-1:0]  hi_q;
    low_req_t         req_q;
    logic             final_beat;

    assign load = start_i && !busy;

    bcol_capture #(.COL_W(COL_W)) u_capture (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .col   (col_i),
        .len   (len_i),
        .ilv   (ilv_i),
        .hi_q  (hi_q),
        .req_q (req_q)
    );

    bcol_beat_cnt u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .span       (req_q.span),
        .busy       (busy),
        .beat       (beat),
        .final_beat (final_beat)
    );

    bcol_order u_order (
        .req  (req_q),
        .beat (beat),
        .low  (low)
    );

    assign beat_vld_o = busy;
    assign last_o     = final_beat;
    assign col_o      = busy ? {hi_q, low} : '0;

endmodule

// File: rtl/bcol_gen_chk.sv
module bcol_gen_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [COL_W-1:0] col_i,
    input logic             beat_vld_o,
    input logic [COL_W-1:0] col_o,
    input logic             last_o
);

    p_last_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
        last_o |-> beat_vld_o);

    p_idle_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        last_o |=> !beat_vld_o);

    p_burst_continues_r1: assert property (@(posedge clk) disable iff (rst)
        (beat_vld_o && !last_o) |=> beat_vld_o);

    p_first_beat_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !beat_vld_o) |=> (beat_vld_o && col_o == $past(col_i)));

    p_upper_held_r5: assert property (@(posedge clk) disable iff (rst)
        (beat_vld_o && !last_o) |=> $stable(col_o[COL_W-1:3]));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !beat_vld_o |-> (col_o == '0 && !last_o));

endmodule

bind bcol_gen bcol_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .col_i      (col_i),
    .beat_vld_o (beat_vld_o),
    .col_o      (col_o),
    .last_o     (last_o)
);

// File: tb/bcol_gen_bench.sv
`timescale 1ns/1ps
module bcol_gen_bench;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic [1:0]       len_i = '0;
    logic             ilv_i = 1'b0;
    logic             beat_vld_o;
    logic [COL_W-1:0] col_o;
    logic             last_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bcol_gen #(.COL_W(COL_W)) u_bcol_gen (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .col_i      (col_i),
        .len_i      (len_i),
        .ilv_i      (ilv_i),
        .beat_vld_o (beat_vld_o),
        .col_o      (col_o),
        .last_o     (last_o)
    );

    // vector: col[36:27] len[26:25] ilv[24] lows beat0..beat7 [23:0]
    localparam int NVEC = 9;
    localparam logic [36:0] VECS [NVEC] = '{
        {10'd5,   2'd2, 1'b0, {3'd5,3'd6,3'd7,3'd0,3'd1,3'd2,3'd3,3'd4}},
        {10'd5,   2'd2, 1'b1, {3'd5,3'd4,3'd7,3'd6,3'd1,3'd0,3'd3,3'd2}},
        {10'd1,   2'd1, 1'b0, {3'd1,3'd2,3'd3,3'd0,12'd0}},
        {10'd1,   2'd1, 1'b1, {3'd1,3'd0,3'd3,3'd2,12'd0}},
        {10'd1,   2'd0, 1'b0, {3'd1,3'd0,18'd0}},
        {10'd1,   2'd0, 1'b1, {3'd1,3'd0,18'd0}},
        {10'h3F7, 2'd1, 1'b0, {3'd7,3'd4,3'd5,3'd6,12'd0}},
        {10'h3F7, 2'd1, 1'b1, {3'd7,3'd6,3'd5,3'd4,12'd0}},
        {10'h2A3, 2'd3, 1'b1, {3'd3,3'd2,3'd1,3'd0,3'd7,3'd6,3'd5,3'd4}}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int beats_of(input int code);
        return (code == 0) ? 2 : (code == 1) ? 4 : 8;
    endfunction

    function automatic int ref_low(input int s, input int n, input bit x, input int k);
        int field;
        if (x) return s ^ k;
        field = s % n;
        return s - field + ((field + k) % n);
    endfunction

    // start at a negedge; sample each beat at the following negedges
    task automatic run_burst(input int col, input int code, input bit x,
                             input bit hold_start, input int alt_col);
        int n;
        n = beats_of(code);
        start_i = 1'b1; col_i = col[COL_W-1:0]; len_i = code[1:0]; ilv_i = x;
        @(negedge clk);
        if (hold_start) col_i = alt_col[COL_W-1:0];
        else start_i = 1'b0;
        for (int k = 0; k < n; k++) begin
            int expc;
            expc = (col & ~7) | ref_low(col & 7, n, x, k);
            check(beat_vld_o === 1'b1, "R1 beat valid", beat_vld_o, 1);
            check(col_o === expc[COL_W-1:0], x ? "R4/R5 interleave column" : "R3/R5 sequential column",
                  col_o, expc);
            check(last_o === (k == n - 1), "R6 last flag", last_o, k == n - 1);
            @(negedge clk);
        end
        check(beat_vld_o === 1'b0, hold_start ? "R7 idle after last" : "R1 burst length",
              beat_vld_o, 0);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        start_i = 1'b1;
        col_i = 10'h155;
        repeat (3) @(negedge clk);
        check(beat_vld_o === 1'b0, "R8 reset valid", beat_vld_o, 0);
        check(last_o === 1'b0, "R8 reset last", last_o, 0);
        check(col_o === '0, "R8 reset column", col_o, 0);
        rst = 1'b0;
        start_i = 1'b0;
        @(negedge clk);
        check(beat_vld_o === 1'b0 && col_o === '0, "R8 after reset", col_o, 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [36:0] e;
            int n;
            e = VECS[v];
            n = beats_of(int'(e[26:25]));
            start_i = 1'b1; col_i = e[36:27]; len_i = e[26:25]; ilv_i = e[24];
            @(negedge clk);
            start_i = 1'b0;
            for (int k = 0; k < n; k++) begin
                logic [COL_W-1:0] expc;
                expc = {e[36:30], e[23 - 3*k -: 3]};
                check(col_o === expc, "R2/R3/R4 table column", col_o, expc);
                check(last_o === (k == n - 1), "R6 table last", last_o, k == n - 1);
                @(negedge clk);
            end
            check(beat_vld_o === 1'b0, "R1 table length", beat_vld_o, 0);
        end

        for (int code = 0; code < 4; code++)
            for (int x = 0; x < 2; x++)
                for (int s = 0; s < 8; s++)
                    run_burst(((s * 37 + code * 11 + x * 5) << 3) | s, code, x[0], 1'b0, 0);

        run_burst(10'h1D6, 2, 1'b0, 1'b1, 10'h0A9);
        run_burst(10'h0E9, 1, 1'b1, 1'b1, 10'h3FF);
        run_burst(10'h27B, 0, 1'b0, 1'b1, 10'h100);

        rst = 1'b1;
        start_i = 1'b1; col_i = 10'h3C4; len_i = 2'd2;
        @(negedge clk);
        rst = 1'b0;
        check(beat_vld_o === 1'b0, "R8 reset mid-stream", beat_vld_o, 0);
        start_i = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule